// File: doc/BRIEF.md
# Disk DMA Transfer Sequencer

This block runs the storage side of a DMA command whose host buffer is split into a chain of segments. A descriptor engine hands over one segment at a time as a one-cycle start strobe with a length and a host address. The drive side arms the transfer first. It supplies the mode (disk or optical packet), the sector count or packet size, the starting sector or logical block, and the command code. For each segment the block works out the byte offset on the storage device. It then issues a single request of the segment length over a request/acknowledge handshake and updates its remaining-size and byte-index counters. It reports the end of the segment, the end of the command, or an error.

Disk mode counts in 512-byte sectors. Optical mode counts in 2048-byte blocks. An optical block address of all ones selects a non-block transfer: one clipped copy is made and the command completes. A segment that arrives before the drive side has armed the transfer is handed back with a pause pulse and no error. The descriptor engine can then restart the channel later.

Top module: `dma_xfer_seq`

## Requirements
- R1: After synchronous reset, every pulse output and `stoReq` are low and `drvStatus` is 8'h00.
- R2: An arm strobe, accepted only while the block is idle, clears the byte index. It loads the remaining size with `armSectors`*512 in disk mode (`armOptical`=0) or with `armPktSize` in optical mode (`armOptical`=1).
- R3: In disk mode a request's `stoOffset` equals (`armSector` << 9) plus the byte index before that segment.
- R4: In optical block mode a request's `stoOffset` equals (`armLba` << 11) plus the byte index before that segment.
- R5: A segment started while the transfer is not armed produces exactly one `segPause` pulse and no request, no `segDone` and no `dmaErr`.
- R6: A segment that meets a remaining size of zero or below ends the command with one `segDone` and one `cmdDone` pulse, and the transfer is disarmed. In disk mode this also sets `drvStatus` to 8'h50 (ready bit 6, seek-complete bit 4) and pulses `drvIrq`; optical mode gives no `drvIrq`.
- R7: A zero-length segment produces a single `segDone` pulse with no request and leaves the counters unchanged.
- R8: A block segment issues one request with `stoLen` equal to the segment length and `stoAddr` equal to the segment address. The remaining size drops by that length and the index grows by it. If the remaining size is then zero or below, the acknowledge cycle also ends the command as in R6.
- R9: In optical mode with `armLba` all ones, a segment issues one request with `stoKind`=2 (copy), `stoOffset`=0 and `stoLen` = min(remaining size, segment length). It then ends the command with `segDone` and `cmdDone` and no `drvIrq`.
- R10: In disk mode, command code 0 gives `stoKind`=0 (read) and code 1 gives `stoKind`=1 (write). Codes 2 and 3 give `dmaErr` and `segDone` with no request and disarm the transfer. Optical block requests are always reads.
- R11: An acknowledge with `stoErr` high gives `dmaErr` and `segDone`, no `cmdDone`, and disarms the transfer.
- R12: Every status pulse lasts one cycle, `cmdDone` never appears without `segDone`, and `stoReq` stays high until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| armStart | input | 1 | Drive side arms a transfer (one cycle) |
| armOptical | input | 1 | 1 = optical packet mode, 0 = disk mode |
| armSectors | input | 16 | Disk sector count |
| armPktSize | input | 32 | Optical packet transfer size in bytes |
| armSector | input | 32 | Disk starting sector number |
| armLba | input | 32 | Optical logical block address, all ones = non-block |
| armCmd | input | 2 | Disk command code: 0 read, 1 write, others invalid |
| segStart | input | 1 | Descriptor engine presents a segment (one cycle) |
| segLen | input | 32 | Segment length in bytes |
| segAddr | input | 32 | Segment host address |
| stoReq | output | 1 | Storage request valid |
| stoKind | output | 2 | 0 read, 1 write, 2 copy |
| stoOffset | output | 48 | Storage byte offset |
| stoLen | output | 32 | Request length in bytes |
| stoAddr | output | 32 | Host address for the request |
| stoAck | input | 1 | Storage acknowledges the request |
| stoErr | input | 1 | Request failed (valid with `stoAck`) |
| segDone | output | 1 | Segment finished pulse |
| segPause | output | 1 | Segment not processed, transfer not armed |
| cmdDone | output | 1 | Command finished pulse |
| drvIrq | output | 1 | Drive interrupt pulse at disk command end |
| dmaErr | output | 1 | DMA error pulse to the drive side |
| drvStatus | output | 8 | Drive status byte |

## Verification
The case that is hardest to reach is a command that ends on the acknowledge of its last request. The remaining size must reach zero or go negative exactly at the issue, and both end pulses must then come out in the same cycle as the handshake closes. Random runs draw segment lengths in 256-byte steps, including zero, against small sector counts, so many commands overshoot the remaining size or land exactly on it. Directed cases cover the end-on-empty segment, a segment on a disarmed channel, a bad command code, a storage error, and both directions of the non-block clip.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;
  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_COPY  = 2'd2
  } reqKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // arm accepted: load counters and context
    logic latchSeg;  // capture the incoming segment
    logic issue;     // build and register a storage request
    logic setReady;  // disk command end: status ready + seek
  } dpStrobe_t;

  // conditions from datapath to control
  typedef struct packed {
    logic remNonPos;
    logic lenZero;
    logic nonBlock;
    logic cmdBad;
    logic optical;
  } dpFlags_t;
endpackage

// File: rtl/dma_xfer_dp.sv
module dma_xfer_dp
  import dma_xfer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int SECT_W = 16,
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 48,
  parameter int DISK_BLK = 512,
  parameter int OPT_BLK  = 2048
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         strobe,
  input  logic              armOptical,
  input  logic [SECT_W-1:0] armSectors,
  input  logic [CNT_W-1:0]  armPktSize,
  input  logic [31:0]       armSector,
  input  logic [31:0]       armLba,
  input  logic [1:0]        armCmd,
  input  logic [CNT_W-1:0]  segLen,
  input  logic [ADDR_W-1:0] segAddr,
  output dpFlags_t          flags,
  output logic [1:0]        reqKind,
  output logic [OFS_W-1:0]  reqOffset,
  output logic [CNT_W-1:0]  reqLen,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [7:0]        drvStatus
);
  localparam int DISK_SH = $clog2(DISK_BLK);
  localparam int OPT_SH  = $clog2(OPT_BLK);
  localparam logic [7:0] STAT_READY_SEEK = 8'h50;

  logic               modeOpt;
  logic [1:0]         cmdReg;
  logic [31:0]        sectorReg;
  logic [31:0]        lbaReg;
  logic signed [CNT_W-1:0] remReg;
  logic [CNT_W-1:0]   idxReg;
  logic [CNT_W-1:0]   segLenReg;
  logic [ADDR_W-1:0]  segAddrReg;

  logic [OFS_W-1:0]   baseOfs;
  logic [CNT_W-1:0]   clipLen;
  logic [CNT_W-1:0]   diskBytes;

  assign diskBytes = CNT_W'(armSectors) << DISK_SH;
  assign baseOfs   = modeOpt ? (OFS_W'(lbaReg) << OPT_SH)
                             : (OFS_W'(sectorReg) << DISK_SH);
  assign clipLen   = ($unsigned(remReg) < segLenReg) ? $unsigned(remReg) : segLenReg;

  assign flags.remNonPos = (remReg <= 0);
  assign flags.lenZero   = (segLenReg == '0);
  assign flags.nonBlock  = modeOpt && (&lbaReg);
  assign flags.cmdBad    = !modeOpt && (cmdReg > 2'd1);
  assign flags.optical   = modeOpt;

  always_ff @(posedge clk) begin
    if (rst) begin
      modeOpt    <= 1'b0;
      cmdReg     <= '0;
      sectorReg  <= '0;
      lbaReg     <= '0;
      remReg     <= '0;
      idxReg     <= '0;
      segLenReg  <= '0;
      segAddrReg <= '0;
      reqKind    <= KIND_READ;
      reqOffset  <= '0;
      reqLen     <= '0;
      reqAddr    <= '0;
      drvStatus  <= '0;
    end else begin
      if (strobe.load) begin
        modeOpt   <= armOptical;
        cmdReg    <= armCmd;
        sectorReg <= armSector;
        lbaReg    <= armLba;
        remReg    <= armOptical ? $signed(armPktSize) : $signed(diskBytes);
        idxReg    <= '0;
      end
      if (strobe.latchSeg) begin
        segLenReg  <= segLen;
        segAddrReg <= segAddr;
      end
      if (strobe.issue) begin
        reqAddr   <= segAddrReg;
        segLenReg <= '0;
        if (flags.nonBlock) begin
          reqKind   <= KIND_COPY;
          reqOffset <= '0;
          reqLen    <= clipLen;
          remReg    <= $signed(clipLen);
        end else begin
          reqKind   <= (modeOpt || cmdReg == 2'd0) ? KIND_READ : KIND_WRITE;
          reqOffset <= baseOfs + OFS_W'(idxReg);
          reqLen    <= segLenReg;
          remReg    <= remReg - $signed(segLenReg);
          idxReg    <= idxReg + segLenReg;
        end
      end
      if (strobe.setReady) drvStatus <= STAT_READY_SEEK;
    end
  end

  // R8: a block issue moves bytes from remaining to index, sum unchanged
  assert_sum_kept_R8: assert property (@(posedge clk) disable iff (rst)
    (strobe.issue && !flags.nonBlock) |=>
      (remReg + $signed(idxReg)) == $past(remReg + $signed(idxReg)));

  // R9: a copy never exceeds the segment length nor the remaining size
  assert_copy_clipped_R9: assert property (@(posedge clk) disable iff (rst)
    (strobe.issue && flags.nonBlock) |=>
      (reqLen <= $past(segLenReg)) && ($signed(reqLen) <= $past(remReg)));
endmodule

// File: rtl/dma_xfer_ctl.sv
module dma_xfer_ctl
  import dma_xfer_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      armStart,
  input  logic      segStart,
  input  logic      stoAck,
  input  logic      stoErr,
  input  dpFlags_t  flags,
  output dpStrobe_t strobe,
  output logic      stoReq,
  output logic      segDone,
  output logic      segPause,
  output logic      cmdDone,
  output logic      drvIrq,
  output logic      dmaErr
);
  typedef enum logic [1:0] {ST_IDLE, ST_EVAL, ST_WAIT} ctlState_e;

  ctlState_e state;
  logic      armed;
  logic      copyReg;
  logic      evalGo;
  logic      ackOk;

  assign evalGo = (state == ST_EVAL) && armed;
  assign ackOk  = (state == ST_WAIT) && stoAck && !stoErr;

  always_comb begin
    strobe.load     = (state == ST_IDLE) && armStart;
    strobe.latchSeg = (state == ST_IDLE) && segStart && !armStart;
    strobe.issue    = evalGo && !flags.remNonPos && !flags.lenZero && !flags.cmdBad;
    strobe.setReady = !flags.optical &&
                      ((evalGo && flags.remNonPos) ||
                       (ackOk && !copyReg && flags.remNonPos));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      armed    <= 1'b0;
      copyReg  <= 1'b0;
      stoReq   <= 1'b0;
      segDone  <= 1'b0;
      segPause <= 1'b0;
      cmdDone  <= 1'b0;
      drvIrq   <= 1'b0;
      dmaErr   <= 1'b0;
    end else begin
      segDone  <= 1'b0;
      segPause <= 1'b0;
      cmdDone  <= 1'b0;
      drvIrq   <= 1'b0;
      dmaErr   <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (armStart) armed <= 1'b1;
          else if (segStart) state <= ST_EVAL;
        end
        ST_EVAL: begin
          state <= ST_IDLE;
          if (!armed) begin
            segPause <= 1'b1;
          end else if (flags.remNonPos) begin
            segDone <= 1'b1;
            cmdDone <= 1'b1;
            drvIrq  <= !flags.optical;
            armed   <= 1'b0;
          end else if (flags.lenZero) begin
            segDone <= 1'b1;
          end else if (flags.cmdBad) begin
            dmaErr  <= 1'b1;
            segDone <= 1'b1;
            armed   <= 1'b0;
          end else begin
            stoReq  <= 1'b1;
            copyReg <= flags.nonBlock;
            state   <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (stoAck) begin
            stoReq  <= 1'b0;
            state   <= ST_IDLE;
            segDone <= 1'b1;
            if (stoErr) begin
              dmaErr <= 1'b1;
              armed  <= 1'b0;
            end else if (copyReg || flags.remNonPos) begin
              cmdDone <= 1'b1;
              drvIrq  <= !flags.optical && !copyReg;
              armed   <= 1'b0;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R12: request held until acknowledged
  assert_req_held_R12: assert property (@(posedge clk) disable iff (rst)
    (stoReq && !stoAck) |=> stoReq);
  // R12: command end always comes with segment end
  assert_cmd_with_seg_R12: assert property (@(posedge clk) disable iff (rst)
    cmdDone |-> segDone);
  // R12: segment end is a single-cycle pulse
  assert_seg_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    segDone |=> !segDone);
  // R5: a request only starts on an armed channel
  assert_req_needs_arm_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(stoReq) |-> $past(armed));
  // R5: a pause carries no error and no request
  assert_pause_clean_R5: assert property (@(posedge clk) disable iff (rst)
    segPause |-> (!dmaErr && !segDone && !stoReq));
  // R6: drive interrupt only at a command end
  assert_irq_at_end_R6: assert property (@(posedge clk) disable iff (rst)
    drvIrq |-> cmdDone);
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
  import dma_xfer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int SECT_W = 16,
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              armStart,
  input  logic              armOptical,
  input  logic [SECT_W-1:0] armSectors,
  input  logic [CNT_W-1:0]  armPktSize,
  input  logic [31:0]       armSector,
  input  logic [31:0]       armLba,
  input  logic [1:0]        armCmd,
  input  logic              segStart,
  input  logic [CNT_W-1:0]  segLen,
  input  logic [ADDR_W-1:0] segAddr,
  output logic              stoReq,
  output logic [1:0]        stoKind,
  output logic [OFS_W-1:0]  stoOffset,
  output logic [CNT_W-1:0]  stoLen,
  output logic [ADDR_W-1:0] stoAddr,
  input  logic              stoAck,
  input  logic              stoErr,
  output logic              segDone,
  output logic              segPause,
  output logic              cmdDone,
  output logic              drvIrq,
  output logic              dmaErr,
  output logic [7:0]        drvStatus
);
  dpStrobe_t strobe;
  dpFlags_t  flags;

  dma_xfer_ctl i_ctl (
    .clk(clk), .rst(rst), .armStart(armStart), .segStart(segStart),
    .stoAck(stoAck), .stoErr(stoErr), .flags(flags), .strobe(strobe),
    .stoReq(stoReq), .segDone(segDone), .segPause(segPause),
    .cmdDone(cmdDone), .drvIrq(drvIrq), .dmaErr(dmaErr)
  );

  dma_xfer_dp #(
    .CNT_W(CNT_W), .SECT_W(SECT_W), .ADDR_W(ADDR_W), .OFS_W(OFS_W)
  ) i_dp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .armOptical(armOptical), .armSectors(armSectors), .armPktSize(armPktSize),
    .armSector(armSector), .armLba(armLba), .armCmd(armCmd),
    .segLen(segLen), .segAddr(segAddr), .flags(flags),
    .reqKind(stoKind), .reqOffset(stoOffset), .reqLen(stoLen),
    .reqAddr(stoAddr), .drvStatus(drvStatus)
  );
endmodule

// File: tb/test_dma_xfer_seq.sv
module test_dma_xfer_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic armStart = 0, armOptical = 0;
  logic [15:0] armSectors = 0;
  logic [31:0] armPktSize = 0, armSector = 0, armLba = 0;
  logic [1:0]  armCmd = 0;
  logic segStart = 0;
  logic [31:0] segLen = 0, segAddr = 0;
  logic stoAck = 0, stoErr = 0;
  logic stoReq, segDone, segPause, cmdDone, drvIrq, dmaErr;
  logic [1:0]  stoKind;
  logic [47:0] stoOffset;
  logic [31:0] stoLen, stoAddr;
  logic [7:0]  drvStatus;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  // model state
  bit     mArmed = 0, mOpt = 0;
  longint mRem = 0, mIdx = 0;
  longint mSector = 0, mLba = 0;
  int     mCmd = 0;

  always #4 clk = ~clk;

  dma_xfer_seq i_dma_xfer_seq (
    .clk(clk), .rst(rst), .armStart(armStart), .armOptical(armOptical),
    .armSectors(armSectors), .armPktSize(armPktSize), .armSector(armSector),
    .armLba(armLba), .armCmd(armCmd), .segStart(segStart), .segLen(segLen),
    .segAddr(segAddr), .stoReq(stoReq), .stoKind(stoKind), .stoOffset(stoOffset),
    .stoLen(stoLen), .stoAddr(stoAddr), .stoAck(stoAck), .stoErr(stoErr),
    .segDone(segDone), .segPause(segPause), .cmdDone(cmdDone), .drvIrq(drvIrq),
    .dmaErr(dmaErr), .drvStatus(drvStatus)
  );

  task automatic check(input string what, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic doArm(input bit opt, input int sectors, input int pkt,
                       input longint sector, input longint lba, input int cmd);
    @(negedge clk);
    armStart = 1; armOptical = opt; armSectors = 16'(sectors);
    armPktSize = 32'(pkt); armSector = 32'(sector); armLba = 32'(lba);
    armCmd = 2'(cmd);
    @(negedge clk);
    armStart = 0;
    mArmed = 1; mOpt = opt; mSector = sector; mLba = lba; mCmd = cmd;
    mRem = opt ? longint'(pkt) : longint'(sectors) * 512; mIdx = 0;
  endtask

  task automatic runSeg(input string tag, input longint len, input int addr,
                        input bit errAck);
    int eReq = 0, ePause = 0, eSeg = 0, eCmd = 0, eIrq = 0, eErr = 0;
    int eKind = 0;
    longint eOfs = 0, eLen = 0;
    int nReq = 0, nPause = 0, nSeg = 0, nCmd = 0, nIrq = 0, nErr = 0;
    longint gKind = 0, gOfs = 0, gLen = 0, gAddr = 0;
    bit diskEnd = 0;
    // expected outcome from the requirements
    if (!mArmed) ePause = 1;
    else if (mRem <= 0) begin
      eSeg = 1; eCmd = 1; eIrq = mOpt ? 0 : 1; mArmed = 0; diskEnd = !mOpt;
    end else if (len == 0) eSeg = 1;
    else if (mOpt && mLba == 64'hFFFF_FFFF) begin
      eReq = 1; eKind = 2; eOfs = 0; eLen = (mRem < len) ? mRem : len;
      mRem = eLen; eSeg = 1; mArmed = 0;
      if (errAck) eErr = 1; else eCmd = 1;
    end else if (!mOpt && mCmd > 1) begin
      eErr = 1; eSeg = 1; mArmed = 0;
    end else begin
      eReq = 1; eLen = len;
      eKind = (mOpt || mCmd == 0) ? 0 : 1;
      eOfs = (mOpt ? (mLba << 11) : (mSector << 9)) + mIdx;
      mRem -= len; mIdx += len; eSeg = 1;
      if (errAck) begin eErr = 1; mArmed = 0; end
      else if (mRem <= 0) begin
        eCmd = 1; eIrq = mOpt ? 0 : 1; mArmed = 0; diskEnd = !mOpt;
      end
    end
    // drive the segment and act as the storage side
    @(negedge clk);
    segStart = 1; segLen = 32'(len); segAddr = addr;
    @(negedge clk);
    segStart = 0;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (stoAck) begin stoAck = 0; stoErr = 0; end
      nPause += int'(segPause); nSeg += int'(segDone); nCmd += int'(cmdDone);
      nIrq += int'(drvIrq); nErr += int'(dmaErr);
      if (stoReq && nReq == 0) begin
        nReq = 1; gKind = stoKind; gOfs = stoOffset; gLen = stoLen; gAddr = stoAddr;
        stoAck = 1; stoErr = errAck;
      end
    end
    check({tag, " request count"}, nReq, eReq);
    check({tag, " R5 pause pulses"}, nPause, ePause);
    check({tag, " R12 segDone pulses"}, nSeg, eSeg);
    check({tag, " R12 cmdDone pulses"}, nCmd, eCmd);
    check({tag, " R6 drvIrq pulses"}, nIrq, eIrq);
    check({tag, " R11 dmaErr pulses"}, nErr, eErr);
    if (eReq == 1 && nReq == 1) begin
      check({tag, " R10 stoKind"}, gKind, eKind);
      check({tag, " R3 R4 stoOffset"}, gOfs, eOfs);
      check({tag, " R8 stoLen"}, gLen, eLen);
      check({tag, " R8 stoAddr"}, gAddr, longint'(unsigned'(addr)));
    end
    if (diskEnd) check({tag, " R6 drvStatus"}, drvStatus, 64'h50);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 stoReq", stoReq, 0);
    check("R1 pulses", {segDone, segPause, cmdDone, drvIrq, dmaErr}, 0);
    check("R1 drvStatus", drvStatus, 0);

    // R5: segment before any arm
    runSeg("R5 unarmed", 512, 32'h1000, 0);

    // R2 R3: disk read two sectors, exact landing
    doArm(0, 2, 0, 100, 0, 0);
    runSeg("R2 disk first", 512, 32'h2000, 0);
    runSeg("R2 disk last", 512, 32'h2200, 0);
    runSeg("R6 after end", 512, 32'h2400, 0);

    // R7 then R6 end-on-empty via overshoot then empty segment path
    doArm(0, 1, 0, 7, 0, 1);
    runSeg("R7 zero len", 0, 32'h3000, 0);
    runSeg("R10 write overshoot", 1024, 32'h3100, 0);

    // R6: command armed with zero sectors ends on first segment
    doArm(0, 0, 0, 9, 0, 0);
    runSeg("R6 empty disk", 256, 32'h3200, 0);
    doArm(1, 0, 0, 0, 3, 0);
    runSeg("R6 empty optical", 256, 32'h3300, 0);

    // R10: bad command code
    doArm(0, 4, 0, 5, 0, 2);
    runSeg("R10 bad cmd", 512, 32'h4000, 0);
    runSeg("R10 disarmed", 512, 32'h4100, 0);

    // R11: storage error
    doArm(0, 4, 0, 12, 0, 1);
    runSeg("R11 ok seg", 512, 32'h5000, 0);
    runSeg("R11 error seg", 512, 32'h5200, 1);
    runSeg("R11 disarmed", 512, 32'h5400, 0);

    // R9: non-block clip both ways
    doArm(1, 0, 300, 0, 64'hFFFF_FFFF, 0);
    runSeg("R9 clip to size", 1000, 32'h6000, 0);
    doArm(1, 0, 3000, 0, 64'hFFFF_FFFF, 0);
    runSeg("R9 clip to seg", 800, 32'h6100, 0);

    // R4: optical block read
    doArm(1, 0, 4096, 0, 33, 1);
    runSeg("R4 opt a", 2048, 32'h7000, 0);
    runSeg("R4 opt b", 2048, 32'h7800, 0);

    // random disk commands
    for (int k = 0; k < 8; k++) begin
      doArm(0, 1 + int'($urandom % 6), 0, longint'($urandom % 32'h00FF_FFFF), 0,
            int'($urandom % 2));
      for (int s = 0; s < 30 && mArmed; s++)
        runSeg("R8 rnd disk", longint'(($urandom % 5) * 256), int'($urandom), 0);
    end
    // random optical commands
    for (int k = 0; k < 8; k++) begin
      doArm(1, 0, 1 + int'($urandom % 5000), 0, longint'($urandom % 32'h0FFF_FFFF), 0);
      for (int s = 0; s < 30 && mArmed; s++)
        runSeg("R4 rnd opt", longint'($urandom % 2048), int'($urandom), 0);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule